// File: doc/BRIEF.md
# Bakery Ticket Mutual-Exclusion Arbiter

This block hands one shared critical resource to one of `N_CLIENTS` clients at a time. It orders the clients by ticket numbers, in the way a bakery queue works. A client asks for the resource with a one-cycle request pulse. It then spends exactly one cycle in an entering phase. During that cycle its ticket is formed as one more than the largest ticket any client holds. The ticket is written at the end of that cycle.

Among the clients that hold a ticket and are waiting, the grant goes to the one with the smallest (ticket, client index) pair. The ticket is the more significant field and the lower index breaks ties. The winner keeps its grant until it pulses release, which also clears its ticket to zero.

No grant decision is taken while another client holds the grant or while any client is entering. When a client releases a ticket value that no other client shares, every larger ticket is lowered by one in the same cycle. The held values therefore stay packed from 1 upward and never exceed `N_CLIENTS`.

Each client runs a four-state machine. The states are `CL_IDLE` (no ticket), `CL_ENTER` (ticket being formed), `CL_WAIT` (ticket held, no grant) and `CL_OWN` (granted). Its transitions are:
- request (`CL_IDLE` to `CL_ENTER`)
- ticket written (`CL_ENTER` to `CL_WAIT`, unconditional)
- won (`CL_WAIT` to `CL_OWN`)
- release (`CL_OWN` to `CL_IDLE`)

Top module: `bakery_arbiter`

## Requirements
- R1: After reset every grant output is 0 and every ticket field reads 0.
- R2: A client whose request is sampled into an idle system gets ticket 1 and sees its grant at the second clock edge after the request was sampled.
- R3: A new ticket equals 1 plus the largest ticket held after that same edge's release adjustment. It reads 0 after the edge that samples the request and appears on `ticket_o` after the next edge.
- R4: Clients whose requests are sampled at the same edge receive the same ticket, and the one with the lowest index is granted first.
- R5: At most one grant is high at any time. The grant goes to the waiting client with the smallest ticket, lower index first on equal tickets, whatever their indices otherwise are.
- R6: A grant stays high until its client pulses release. At the edge that samples the release, the grant drops and the client's ticket becomes 0.
- R7: No client wins at an edge where any client is in its entering cycle or any client holds the grant. After a release, the next grant therefore rises one edge later, or two edges later if some client is entering during the cycle after the release.
- R8: When the releasing client's ticket value is held by no other client, every larger ticket is lowered by 1 at the release edge. No ticket ever exceeds `N_CLIENTS`.
- R9: A request from a client that already holds a ticket or a grant is ignored, and so is a release from a client that holds no grant. Neither changes any grant or ticket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_CLIENTS | One-cycle request pulse per client |
| rel_i | input | N_CLIENTS | One-cycle release pulse per client |
| gnt_o | output | N_CLIENTS | Grant per client, one-hot or zero |
| ticket_o | output | N_CLIENTS*TKT_W | Ticket of client i in bits [i*TKT_W +: TKT_W], 0 = none |

## Verification
Relative to the edge that samples a request, the ticket field still reads 0 after that edge and holds its value after the next edge. The grant rises one edge after that when no owner is present. A release clears the grant and ticket at its own sampling edge, and any ticket lowering shows up at that same edge. The next grant follows one edge later, or two when a client is entering. The bench drives and samples on falling edges and steps a known number of rising edges between a stimulus and each check, so every value is read in the exact cycle it is due. The entering stall is tested by landing a new request on the release edge and checking that the grant is still low one edge after the release.

// File: rtl/bakery_pkg.sv
package bakery_pkg;

    // Per-client life cycle.
    typedef enum logic [1:0] {
        CL_IDLE  = 2'd0,
        CL_ENTER = 2'd1,
        CL_WAIT  = 2'd2,
        CL_OWN   = 2'd3
    } cl_state_e;

endpackage

// File: rtl/bakery_client_fsm.sv
module bakery_client_fsm
    import bakery_pkg::*;
#(
    parameter int TKT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             rel_i,
    input  logic             win_i,
    input  logic [TKT_W-1:0] new_tkt_i,
    input  logic [TKT_W-1:0] adj_tkt_i,
    output logic             entering_o,
    output logic             waiting_o,
    output logic             owning_o,
    output logic [TKT_W-1:0] tkt_o
);

    cl_state_e        state_q;
    cl_state_e        state_d;
    logic [TKT_W-1:0] tkt_q;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CL_IDLE:  if (req_i) state_d = CL_ENTER;
            CL_ENTER: state_d = CL_WAIT;
            CL_WAIT:  if (win_i) state_d = CL_OWN;
            CL_OWN:   if (rel_i) state_d = CL_IDLE;
            default:  state_d = CL_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CL_IDLE;
        else        state_q <= state_d;
    end

    // Ticket register: written on leaving ENTER, follows compaction while held.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tkt_q <= '0;
        end else begin
            unique case (state_q)
                CL_ENTER: tkt_q <= new_tkt_i;
                CL_WAIT:  tkt_q <= adj_tkt_i;
                CL_OWN:   tkt_q <= rel_i ? '0 : adj_tkt_i;
                default:  tkt_q <= '0;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        entering_o = 1'b0;
        waiting_o  = 1'b0;
        owning_o   = 1'b0;
        unique case (state_q)
            CL_IDLE:  ;
            CL_ENTER: entering_o = 1'b1;
            CL_WAIT:  waiting_o  = 1'b1;
            CL_OWN:   owning_o   = 1'b1;
            default:  ;
        endcase
    end

    assign tkt_o = tkt_q;

endmodule

// File: rtl/bakery_ticket_calc.sv
module bakery_ticket_calc #(
    parameter int N_CLIENTS = 4,
    parameter int TKT_W     = 3
) (
    input  logic [N_CLIENTS*TKT_W-1:0] tkt_flat_i,
    input  logic [N_CLIENTS-1:0]       rel_fire_i,
    output logic [N_CLIENTS*TKT_W-1:0] adj_flat_o,
    output logic [TKT_W-1:0]           new_tkt_o
);

    logic [TKT_W-1:0] tk  [N_CLIENTS];
    logic [TKT_W-1:0] adj [N_CLIENTS];
    logic [TKT_W-1:0] rel_val;
    logic             dup;
    logic             shrink;
    logic [TKT_W-1:0] max_val;

    for (genvar g = 0; g < N_CLIENTS; g++) begin : g_unpack
        assign tk[g]                        = tkt_flat_i[g*TKT_W +: TKT_W];
        assign adj_flat_o[g*TKT_W +: TKT_W] = adj[g];
    end

    // Value being released, and whether any other client shares it.
    always_comb begin
        rel_val = '0;
        for (int i = 0; i < N_CLIENTS; i++) begin
            if (rel_fire_i[i]) rel_val = tk[i];
        end
        dup = 1'b0;
        for (int i = 0; i < N_CLIENTS; i++) begin
            if (!rel_fire_i[i] && (tk[i] == rel_val) && (rel_val != '0)) dup = 1'b1;
        end
        shrink = (|rel_fire_i) && !dup;
    end

    // Compacted tickets, then the largest of them plus one.
    always_comb begin
        max_val = '0;
        for (int i = 0; i < N_CLIENTS; i++) begin
            if (rel_fire_i[i])
                adj[i] = '0;
            else if (shrink && (tk[i] > rel_val))
                adj[i] = tk[i] - 1'b1;
            else
                adj[i] = tk[i];
            if (adj[i] > max_val) max_val = adj[i];
        end
        new_tkt_o = max_val + 1'b1;
    end

endmodule

// File: rtl/bakery_pick.sv
module bakery_pick #(
    parameter int N_CLIENTS = 4,
    parameter int TKT_W     = 3
) (
    input  logic [N_CLIENTS*TKT_W-1:0] tkt_flat_i,
    input  logic [N_CLIENTS-1:0]       cand_i,
    output logic [N_CLIENTS-1:0]       win_oh_o
);

    logic [TKT_W-1:0] tk [N_CLIENTS];
    logic [TKT_W-1:0] best;
    logic             found;

    for (genvar g = 0; g < N_CLIENTS; g++) begin : g_unpack
        assign tk[g] = tkt_flat_i[g*TKT_W +: TKT_W];
    end

    // Ascending index scan with strict less-than: lower index keeps ties.
    always_comb begin
        found    = 1'b0;
        best     = '0;
        win_oh_o = '0;
        for (int i = 0; i < N_CLIENTS; i++) begin
            if (cand_i[i] && (tk[i] != '0) && (!found || (tk[i] < best))) begin
                found       = 1'b1;
                best        = tk[i];
                win_oh_o    = '0;
                win_oh_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bakery_arbiter.sv
module bakery_arbiter #(
    parameter int N_CLIENTS = 4,
    localparam int TKT_W    = $clog2(N_CLIENTS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CLIENTS-1:0]       req_i,
    input  logic [N_CLIENTS-1:0]       rel_i,
    output logic [N_CLIENTS-1:0]       gnt_o,
    output logic [N_CLIENTS*TKT_W-1:0] ticket_o
);

    logic [N_CLIENTS-1:0]       enter_vec;
    logic [N_CLIENTS-1:0]       wait_vec;
    logic [N_CLIENTS-1:0]       own_vec;
    logic [N_CLIENTS-1:0]       pick_oh;
    logic [N_CLIENTS-1:0]       win_vec;
    logic [N_CLIENTS-1:0]       rel_fire;
    logic [N_CLIENTS*TKT_W-1:0] tkt_flat;
    logic [N_CLIENTS*TKT_W-1:0] adj_flat;
    logic [TKT_W-1:0]           new_tkt;
    logic                       decide;

    for (genvar g = 0; g < N_CLIENTS; g++) begin : g_client
        bakery_client_fsm #(.TKT_W(TKT_W)) client_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (req_i[g]),
            .rel_i      (rel_i[g]),
            .win_i      (win_vec[g]),
            .new_tkt_i  (new_tkt),
            .adj_tkt_i  (adj_flat[g*TKT_W +: TKT_W]),
            .entering_o (enter_vec[g]),
            .waiting_o  (wait_vec[g]),
            .owning_o   (own_vec[g]),
            .tkt_o      (tkt_flat[g*TKT_W +: TKT_W])
        );
    end

    assign rel_fire = own_vec & rel_i;

    bakery_ticket_calc #(.N_CLIENTS(N_CLIENTS), .TKT_W(TKT_W)) calc_i (
        .tkt_flat_i (tkt_flat),
        .rel_fire_i (rel_fire),
        .adj_flat_o (adj_flat),
        .new_tkt_o  (new_tkt)
    );

    bakery_pick #(.N_CLIENTS(N_CLIENTS), .TKT_W(TKT_W)) pick_i (
        .tkt_flat_i (tkt_flat),
        .cand_i     (wait_vec),
        .win_oh_o   (pick_oh)
    );

    // Decide only with no owner and nobody entering.
    assign decide  = !(|enter_vec) && !(|own_vec);
    assign win_vec = pick_oh & {N_CLIENTS{decide}};

    assign gnt_o    = own_vec;
    assign ticket_o = tkt_flat;

endmodule

// File: rtl/bakery_arbiter_chk.sv
module bakery_arbiter_chk #(
    parameter int N_CLIENTS = 4,
    parameter int TKT_W     = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_CLIENTS-1:0]       rel_i,
    input logic [N_CLIENTS-1:0]       gnt_o,
    input logic [N_CLIENTS*TKT_W-1:0] ticket_o,
    input logic [N_CLIENTS-1:0]       entering
);

    // R5
    single_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R6
    gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o & ~rel_i) != '0) |=> ((gnt_o & $past(gnt_o & ~rel_i)) == $past(gnt_o & ~rel_i)));

    // R6
    rel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o & rel_i) != '0) |=> ((gnt_o & $past(gnt_o & rel_i)) == '0));

    // R7
    no_decide_entering_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entering != '0) |=> ((gnt_o & ~$past(gnt_o)) == '0));

    for (genvar g = 0; g < N_CLIENTS; g++) begin : g_per
        // R8
        tkt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ticket_o[g*TKT_W +: TKT_W] <= TKT_W'(N_CLIENTS));

        // R2
        gnt_has_tkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_o[g] |-> (ticket_o[g*TKT_W +: TKT_W] != '0));
    end

endmodule

bind bakery_arbiter bakery_arbiter_chk #(.N_CLIENTS(N_CLIENTS), .TKT_W(TKT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rel_i    (rel_i),
    .gnt_o    (gnt_o),
    .ticket_o (ticket_o),
    .entering (enter_vec)
);

// File: tb/bakery_arbiter_tb.sv
module bakery_arbiter_tb_top;

    localparam int N  = 4;
    localparam int TW = $clog2(N + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_i = '0;
    logic [N-1:0]    rel_i = '0;
    logic [N-1:0]    gnt_o;
    logic [N*TW-1:0] ticket_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bakery_arbiter #(.N_CLIENTS(N)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .rel_i    (rel_i),
        .gnt_o    (gnt_o),
        .ticket_o (ticket_o)
    );

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse(input logic [N-1:0] rq, input logic [N-1:0] rl);
        req_i = rq;
        rel_i = rl;
        step(1);
        req_i = '0;
        rel_i = '0;
    endtask

    task automatic chk_gnt(input logic [N-1:0] exp, input string tag);
        checks++;
        if (gnt_o !== exp) begin
            errors++;
            $display("FAIL %s gnt actual=%b expected=%b", tag, gnt_o, exp);
        end
    endtask

    task automatic chk_tkt(input int idx, input int exp, input string tag);
        checks++;
        if (ticket_o[idx*TW +: TW] !== TW'(exp)) begin
            errors++;
            $display("FAIL %s ticket[%0d] actual=%0d expected=%0d", tag, idx,
                     ticket_o[idx*TW +: TW], exp);
        end
    endtask

    task automatic test_reset();
        chk_gnt('0, "R1");
        for (int i = 0; i < N; i++) chk_tkt(i, 0, "R1");
    endtask

    task automatic test_single();
        pulse(4'b0001, '0);
        chk_tkt(0, 0, "R3");
        step(1);
        chk_tkt(0, 1, "R2");
        chk_gnt('0, "R2");
        step(1);
        chk_gnt(4'b0001, "R2");
        pulse('0, 4'b0001);
        chk_gnt('0, "R6");
        chk_tkt(0, 0, "R6");
    endtask

    task automatic test_same_cycle();
        pulse(4'b0110, '0);
        step(1);
        chk_tkt(1, 1, "R4");
        chk_tkt(2, 1, "R4");
        step(1);
        chk_gnt(4'b0010, "R4");
        pulse(4'b1000, '0);
        step(1);
        chk_tkt(3, 2, "R3");
        pulse('0, 4'b0010);
        chk_gnt('0, "R6");
        chk_tkt(2, 1, "R8");
        chk_tkt(3, 2, "R8");
        step(1);
        chk_gnt(4'b0100, "R5");
        pulse('0, 4'b0100);
        chk_tkt(3, 1, "R8");
        step(1);
        chk_gnt(4'b1000, "R5");
        pulse('0, 4'b1000);
        chk_gnt('0, "R6");
    endtask

    task automatic test_enter_stall();
        pulse(4'b0001, '0);
        step(2);
        chk_gnt(4'b0001, "R2");
        pulse(4'b0010, '0);
        step(1);
        chk_tkt(1, 2, "R3");
        pulse(4'b0100, 4'b0001);
        chk_gnt('0, "R6");
        chk_tkt(1, 1, "R8");
        step(1);
        chk_gnt('0, "R7");
        chk_tkt(2, 2, "R3");
        step(1);
        chk_gnt(4'b0010, "R7");
    endtask

    task automatic test_ignored();
        pulse(4'b0010, 4'b1000);
        chk_gnt(4'b0010, "R9");
        step(1);
        chk_gnt(4'b0010, "R9");
        chk_tkt(1, 1, "R9");
        chk_tkt(3, 0, "R9");
        chk_tkt(2, 2, "R9");
        pulse('0, 4'b0010);
        chk_tkt(2, 1, "R8");
        step(1);
        chk_gnt(4'b0100, "R5");
        pulse('0, 4'b0100);
        chk_gnt('0, "R6");
    endtask

    task automatic test_order_full();
        pulse(4'b1000, '0);
        step(2);
        chk_gnt(4'b1000, "R2");
        pulse(4'b0100, '0);
        step(1);
        pulse(4'b0010, '0);
        step(1);
        pulse(4'b0001, '0);
        step(1);
        chk_tkt(2, 2, "R3");
        chk_tkt(1, 3, "R3");
        chk_tkt(0, 4, "R8");
        pulse('0, 4'b1000);
        chk_tkt(0, 3, "R8");
        step(1);
        chk_gnt(4'b0100, "R5");
        pulse('0, 4'b0100);
        step(1);
        chk_gnt(4'b0010, "R5");
        pulse('0, 4'b0010);
        step(1);
        chk_gnt(4'b0001, "R5");
        pulse('0, 4'b0001);
        chk_gnt('0, "R6");
        for (int i = 0; i < N; i++) chk_tkt(i, 0, "R6");
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        test_reset();
        test_single();
        test_same_cycle();
        test_enter_stall();
        test_ignored();
        test_order_full();
        done = 1'b1;
        finish_sim();
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_sim();
        end
    end

endmodule